// File: doc/BRIEF.md
# PHY Link and Duplex Polling Sequencer

This block looks after two Ethernet PHYs that share one MDC/MDIO management bus. It keeps polling the PHYs, one port after the other, and reads only. On each visit it fetches the basic status register (register 1). It captures the link bit for that port, and it uses the auto-negotiation-complete bit to decide what happens next. A port whose negotiation has not finished is held in half duplex.

When a port's negotiation-complete bit rises, the sequencer makes one extra pass on that port. It reads the local advertisement register (4) and then the partner ability register (5). It then picks the best ability both ends support and sets the port's duplex output to match. After that pass, only register 1 is polled for that port until the complete bit falls again.

The block contains three parts: a clause-22 read-frame engine that generates MDC from the system clock, the polling state machine, and a combinational priority resolver. A low enable input stops the sequencer from starting any new frame.

Top module: `phy_duplex_poller`

## Requirements
- R1: Frames alternate between the two PHY addresses (`PHY_ADDR0` first after reset). A port keeps the bus only while its register 4 and 5 reads are pending, and the next frame then goes to the other port.
- R2: Each frame drives 32 ones, then start bits 0,1, opcode bits 1,0, the 5-bit PHY address MSB first, and the 5-bit register address MSB first. It then releases MDIO (`mdio_oe` low) for the 2 turnaround bits and the 16 data bits. Data is taken MSB first.
- R3: MDC rests low while no frame is in progress. During a frame, each MDC half period lasts `MDC_DIV` clock cycles. MDIO changes only while MDC is low and is sampled on the rising MDC edge.
- R4: `link_up[p]` equals bit 2 of the most recent register 1 value read from port p.
- R5: When register 1 bit 5 reads 0, `full_duplex[p]` goes low and the next frame for that port is again a register 1 read.
- R6: When register 1 bit 5 reads 1 and the port has not yet resolved since that bit was last seen 0, the sequencer reads register 4 and then register 5 of the same PHY. This also applies to the first read after reset.
- R7: While register 1 bit 5 stays 1 after a resolution, registers 4 and 5 are not read again, and changes to their contents have no effect on `full_duplex`.
- R8: The resolution takes the AND of registers 4 and 5 and checks bits in this priority order: bit 8 gives 100BASE-TX full, bit 9 gives 100BASE-T4 half, bit 7 gives 100BASE-TX half, bit 6 gives 10BASE-T full, and anything else gives 10BASE-T half. `full_duplex[p]` is 1 only for the two full-duplex outcomes.
- R9: `full_duplex[p]` can rise only right after a register 5 read of port p completes. It does not change between the register 4 and register 5 reads.
- R10: While `an_enable` is low, no new frame starts. A frame already in progress finishes. Polling resumes where it left off once `an_enable` returns high.
- R11: Reset sets `mdc`, `mdio_oe`, `link_up` and `full_duplex` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| an_enable | input | 1 | Enables polling; when low, no new frame starts |
| mdio_i | input | 1 | MDIO value returned by the PHYs |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the block |
| mdio_oe | output | 1 | MDIO output enable |
| link_up | output | 2 | Latched link status per port |
| full_duplex | output | 2 | Resolved duplex per port (1 = full) |

## Verification
The bench builds the block with `MDC_DIV` = 2, so one frame takes about 256 clocks. This lets a few hundred polls fit in the run, including many rising and falling transitions of the complete bit on both ports. The PHY addresses are 3 and 17: distinct, non-zero, and different in several bit positions, so a swapped, stuck or mis-shifted address field shows up in the decoded header. Directed cases cover each priority level of the resolver, a port that is already negotiated at reset, stale register 4/5 contents while the complete bit stays high, and an enable drop in the middle of polling.

// File: rtl/phy_poll_pkg.sv
`timescale 1ns/1ps
package phy_poll_pkg;
    localparam int FRAME_BITS = 64;
    localparam int HDR_BITS   = 46;
    localparam int DATA_FIRST = 48;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int PRE_BITS   = 32;

    localparam logic [4:0] REG_STATUS = 5'd1;
    localparam logic [4:0] REG_ADV    = 5'd4;
    localparam logic [4:0] REG_LPA    = 5'd5;

    localparam int BIT_LINK   = 2;
    localparam int BIT_ANDONE = 5;
    localparam int ABIL_LSB   = 6;  // abilities of interest: bits 9..6

    typedef enum logic [1:0] {RD_STATUS, RD_ADV, RD_LPA} rd_kind_e;

    typedef enum logic [2:0] {
        AB_10_HALF, AB_10_FULL, AB_100TX_HALF, AB_100T4, AB_100TX_FULL
    } ability_e;

    typedef struct packed {
        logic [4:0] phy;
        logic [4:0] regad;
    } rd_req_t;

    function automatic logic [4:0] kind_addr(rd_kind_e k);
        case (k)
            RD_ADV:  return REG_ADV;
            RD_LPA:  return REG_LPA;
            default: return REG_STATUS;
        endcase
    endfunction

    function automatic logic ability_full(ability_e a);
        return (a == AB_100TX_FULL) || (a == AB_10_FULL);
    endfunction
endpackage

// File: rtl/mdio_read_engine.sv
`timescale 1ns/1ps
module mdio_read_engine
    import phy_poll_pkg::*;
#(
    parameter int MDC_DIV = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  rd_req_t          req,
    input  logic             mdio_i,
    output logic             busy,
    output logic             done,
    output logic [15:0]      rdata,
    output logic [IDX_W-1:0] bit_pos,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe
);
    localparam int DIV_W = (MDC_DIV > 1) ? $clog2(MDC_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(MDC_DIV - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_DATA  = IDX_W'(DATA_FIRST);
    localparam logic [IDX_W-1:0] IDX_HLAST = IDX_W'(HDR_BITS - 1);

    logic [DIV_W-1:0]    div_cnt;
    logic [HDR_BITS-1:0] hdr_sr;
    logic [15:0]         data_sr;
    logic                tick;

    assign tick  = (div_cnt == DIV_LAST);
    assign rdata = data_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            mdc     <= 1'b0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            div_cnt <= '0;
            bit_pos <= '0;
            hdr_sr  <= '0;
            data_sr <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                div_cnt <= '0;
                mdc     <= 1'b0;
                if (start) begin
                    busy    <= 1'b1;
                    bit_pos <= '0;
                    hdr_sr  <= {32'hFFFF_FFFF, 2'b01, 2'b10, req.phy, req.regad};
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b1;
                end
            end else begin
                div_cnt <= tick ? '0 : div_cnt + 1'b1;
                if (tick) begin
                    if (!mdc) begin
                        mdc <= 1'b1;
                        if (bit_pos >= IDX_DATA)
                            data_sr <= {data_sr[14:0], mdio_i};
                    end else begin
                        mdc <= 1'b0;
                        if (bit_pos == IDX_LAST) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            bit_pos <= bit_pos + 1'b1;
                            hdr_sr  <= {hdr_sr[HDR_BITS-2:0], 1'b0};
                            mdio_o  <= hdr_sr[HDR_BITS-2];
                            mdio_oe <= (bit_pos < IDX_HLAST);
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ability_resolver.sv
`timescale 1ns/1ps
module ability_resolver
    import phy_poll_pkg::*;
(
    input  logic [3:0] local_abil,   // register 4 bits 9..6
    input  logic [3:0] partner_abil, // register 5 bits 9..6
    output ability_e   ability
);
    logic [3:0] common;
    assign common = local_abil & partner_abil;

    // index = bit number - ABIL_LSB
    always_comb begin
        if (common[8 - ABIL_LSB])      ability = AB_100TX_FULL;
        else if (common[9 - ABIL_LSB]) ability = AB_100T4;
        else if (common[7 - ABIL_LSB]) ability = AB_100TX_HALF;
        else if (common[6 - ABIL_LSB]) ability = AB_10_FULL;
        else                           ability = AB_10_HALF;
    end
endmodule

// File: rtl/phy_duplex_poller.sv
`timescale 1ns/1ps
module phy_duplex_poller
    import phy_poll_pkg::*;
#(
    parameter int         MDC_DIV   = 10,
    parameter logic [4:0] PHY_ADDR0 = 5'd0,
    parameter logic [4:0] PHY_ADDR1 = 5'd1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       an_enable,
    input  logic       mdio_i,
    output logic       mdc,
    output logic       mdio_o,
    output logic       mdio_oe,
    output logic [1:0] link_up,
    output logic [1:0] full_duplex
);
    localparam logic [4:0] PORT_ADDR [2] = '{PHY_ADDR0, PHY_ADDR1};

    rd_kind_e         cur_kind;
    logic             cur_port;
    logic             waiting;
    logic [1:0]       an_seen;
    logic [3:0]       adv_hold;
    logic             eng_start;
    logic             eng_busy;
    logic             eng_done;
    logic [15:0]      eng_rdata;
    logic [IDX_W-1:0] eng_bit_idx;
    rd_req_t          eng_req;
    ability_e         res_ability;
    logic             unused_rdata_bits;

    assign eng_start     = an_enable && !waiting && !eng_busy;
    assign eng_req.phy   = PORT_ADDR[cur_port];
    assign eng_req.regad = kind_addr(cur_kind);
    assign unused_rdata_bits = ^{eng_rdata[15:10], eng_rdata[4:3], eng_rdata[1:0]};

    mdio_read_engine #(.MDC_DIV(MDC_DIV)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .start   (eng_start),
        .req     (eng_req),
        .mdio_i  (mdio_i),
        .busy    (eng_busy),
        .done    (eng_done),
        .rdata   (eng_rdata),
        .bit_pos (eng_bit_idx),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    ability_resolver u_resolver (
        .local_abil   (adv_hold),
        .partner_abil (eng_rdata[ABIL_LSB+3:ABIL_LSB]),
        .ability      (res_ability)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_kind    <= RD_STATUS;
            cur_port    <= 1'b0;
            waiting     <= 1'b0;
            an_seen     <= '0;
            adv_hold    <= '0;
            link_up     <= '0;
            full_duplex <= '0;
        end else begin
            if (eng_start) waiting <= 1'b1;
            if (eng_done) begin
                waiting <= 1'b0;
                case (cur_kind)
                    RD_STATUS: begin
                        link_up[cur_port] <= eng_rdata[BIT_LINK];
                        if (!eng_rdata[BIT_ANDONE]) begin
                            full_duplex[cur_port] <= 1'b0;
                            an_seen[cur_port]     <= 1'b0;
                            cur_port              <= ~cur_port;
                        end else if (!an_seen[cur_port]) begin
                            cur_kind <= RD_ADV;
                        end else begin
                            cur_port <= ~cur_port;
                        end
                    end
                    RD_ADV: begin
                        adv_hold <= eng_rdata[ABIL_LSB+3:ABIL_LSB];
                        cur_kind <= RD_LPA;
                    end
                    RD_LPA: begin
                        full_duplex[cur_port] <= ability_full(res_ability);
                        an_seen[cur_port]     <= 1'b1;
                        cur_kind              <= RD_STATUS;
                        cur_port              <= ~cur_port;
                    end
                    default: cur_kind <= RD_STATUS;
                endcase
            end
        end
    end
endmodule

// File: rtl/phy_poll_checker.sv
`timescale 1ns/1ps
module phy_poll_checker
    import phy_poll_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             an_enable,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             eng_busy,
    input logic             eng_done,
    input logic [IDX_W-1:0] bit_idx,
    input rd_kind_e         cur_kind,
    input logic             cur_port,
    input logic [1:0]       full_duplex
);
    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !eng_busy |-> !mdc); // R3
    AST_PREAMBLE_ONES: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe && bit_idx < IDX_W'(PRE_BITS)) |-> mdio_o); // R2
    AST_RELEASE_TA_DATA: assert property (@(posedge clk) disable iff (rst)
        (eng_busy && bit_idx >= IDX_W'(HDR_BITS)) |-> !mdio_oe); // R2
    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!an_enable && !eng_busy) |=> !eng_busy); // R10
    AST_FDX0_RISE_AFTER_LPA: assert property (@(posedge clk) disable iff (rst)
        $rose(full_duplex[0]) |-> $past(eng_done && cur_kind == RD_LPA && !cur_port)); // R9
    AST_FDX1_RISE_AFTER_LPA: assert property (@(posedge clk) disable iff (rst)
        $rose(full_duplex[1]) |-> $past(eng_done && cur_kind == RD_LPA && cur_port)); // R9
    AST_FDX0_FALL_ON_STATUS: assert property (@(posedge clk) disable iff (rst)
        $fell(full_duplex[0]) |-> $past(eng_done && cur_kind == RD_STATUS && !cur_port)); // R5
    AST_FDX1_FALL_ON_STATUS: assert property (@(posedge clk) disable iff (rst)
        $fell(full_duplex[1]) |-> $past(eng_done && cur_kind == RD_STATUS && cur_port)); // R5
endmodule

bind phy_duplex_poller phy_poll_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .an_enable   (an_enable),
    .mdc         (mdc),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe),
    .eng_busy    (eng_busy),
    .eng_done    (eng_done),
    .bit_idx     (eng_bit_idx),
    .cur_kind    (cur_kind),
    .cur_port    (cur_port),
    .full_duplex (full_duplex)
);

// File: tb/phy_duplex_poller_bench.sv
`timescale 1ns/1ps
module phy_duplex_poller_bench;
    localparam int         MDC_DIV = 2;
    localparam logic [4:0] A0 = 5'd3;
    localparam logic [4:0] A1 = 5'd17;
    localparam realtime    MDC_PERIOD = 2.0 * MDC_DIV * 4.0;

    logic clk = 1'b0, rst = 1'b1, an_enable = 1'b0, mdio_i = 1'b0;
    logic mdc, mdio_o, mdio_oe;
    logic [1:0] link_up, full_duplex;

    always #2 clk = ~clk;

    phy_duplex_poller #(.MDC_DIV(MDC_DIV), .PHY_ADDR0(A0), .PHY_ADDR1(A1)) u_phy_duplex_poller (
        .clk(clk), .rst(rst), .an_enable(an_enable), .mdio_i(mdio_i),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .link_up(link_up), .full_duplex(full_duplex)
    );

    int checks = 0, fails = 0;
    bit done_flag = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    function automatic bit resolve_full(logic [15:0] a, logic [15:0] b);
        logic [15:0] c = a & b;
        if (c[8]) return 1'b1;
        if (c[9]) return 1'b0;
        if (c[7]) return 1'b0;
        if (c[6]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [4:0] addr_of(int p);
        return (p == 0) ? A0 : A1;
    endfunction

    // PHY register contents served to the block
    logic [15:0] r1 [2];
    logic [15:0] r4 [2];
    logic [15:0] r5 [2];

    // expected state, derived from the requirements
    bit e_seen [2];
    bit e_fd [2];
    bit e_link [2];
    int e_port = 0;
    int e_reg = 1;
    logic [15:0] e_adv = '0;

    int n = 0;
    logic [45:0] hdr = '0;
    logic [15:0] serve = '0;
    int cur_p = 0;
    int frames_started = 0, frames_done = 0;
    realtime t_last = 0;
    bit oe_bad = 0, per_bad = 0;

    task automatic decode_header();
        logic [4:0] phy, rg;
        phy = hdr[9:5];
        rg  = hdr[4:0];
        frames_started++;
        check(hdr[45:14] == 32'hFFFF_FFFF && hdr[13:10] == 4'b0110, "R2 preamble/start/opcode",
              int'(hdr[13:10]), 6);
        check(phy == addr_of(e_port), "R1 port alternation", int'(phy), int'(addr_of(e_port)));
        check(rg == 5'(e_reg), "R5/R6/R7 register select", int'(rg), e_reg);
        check(link_up == {e_link[1], e_link[0]}, "R4 link status", int'(link_up),
              int'({e_link[1], e_link[0]}));
        check(full_duplex == {e_fd[1], e_fd[0]}, (e_reg == 5) ? "R9 duplex held" : "R8 duplex",
              int'(full_duplex), int'({e_fd[1], e_fd[0]}));
        cur_p = (phy == A1) ? 1 : 0;
        serve = (rg == 5'd1) ? r1[cur_p] : (rg == 5'd4) ? r4[cur_p] : r5[cur_p];
    endtask

    task automatic finish_frame();
        check(!oe_bad, "R2 release during turnaround/data", int'(oe_bad), 0);
        check(!per_bad, "R3 MDC half period", int'(per_bad), 0);
        oe_bad = 0;
        per_bad = 0;
        case (e_reg)
            1: begin
                e_link[cur_p] = serve[2];
                if (!serve[5]) begin
                    e_fd[cur_p] = 0; e_seen[cur_p] = 0; e_port ^= 1;
                end else if (!e_seen[cur_p]) e_reg = 4;
                else e_port ^= 1;
            end
            4: begin e_adv = serve; e_reg = 5; end
            default: begin
                e_fd[cur_p] = resolve_full(e_adv, serve);
                e_seen[cur_p] = 1; e_reg = 1; e_port ^= 1;
            end
        endcase
        frames_done++;
    endtask

    // PHY model: decodes the header on rising MDC, drives data after falling MDC
    always @(posedge mdc) begin
        if (n < 46) hdr = {hdr[44:0], mdio_o};
        else if (mdio_oe) oe_bad = 1;
        if (n >= 1 && ($realtime - t_last) != MDC_PERIOD) per_bad = 1;
        t_last = $realtime;
        n++;
        if (n == 46) begin
            #1;
            decode_header();
        end
        if (n == 64) begin
            finish_frame();
            n = 0;
        end
    end

    always @(negedge mdc) begin
        if (n >= 48 && n <= 63) mdio_i = serve[63 - n];
    end

    task automatic wait_frames(input int k);
        int target;
        target = frames_done + k;
        wait (frames_done >= target);
    endtask

    task automatic directed_case(input logic [15:0] adv, input logic [15:0] lpa);
        r1[1][5] = 1'b0;
        wait_frames(4);
        r4[1] = adv;
        r5[1] = lpa;
        r1[1][5] = 1'b1;
        wait_frames(6);
    endtask

    initial begin
        void'($urandom(32'd4242));
        r1[0] = 16'h0004;  // link up, negotiation pending
        r1[1] = 16'h0020;  // negotiated already at reset, link down
        r4[0] = 16'h01E1; r5[0] = 16'h01E1;
        r4[1] = 16'h01E0; r5[1] = 16'h0140;  // common bits 8,6 -> full
        repeat (5) @(posedge clk);
        #1;
        check(mdc == 0 && mdio_oe == 0, "R11 reset bus idle", int'({mdc, mdio_oe}), 0);
        check(link_up == 0 && full_duplex == 0, "R11 reset outputs",
              int'({link_up, full_duplex}), 0);
        @(negedge clk);
        rst = 1'b0;
        an_enable = 1'b1;
        wait_frames(8);   // R6: port 1 resolves from first read after reset

        // R8 priority corners on port 1
        directed_case(16'h01E0, 16'h01E0);  // bit 8 -> full
        directed_case(16'h03E0, 16'h02A0);  // bit 9 beats 7 -> half
        directed_case(16'h00E0, 16'h00A0);  // bit 7 -> half
        directed_case(16'h0060, 16'h0040);  // bit 6 -> full
        directed_case(16'h0100, 16'h0080);  // nothing common -> half
        directed_case(16'h0140, 16'h0240);  // bit 6 only -> full

        // R7: stale 4/5 contents while negotiated stays high
        r4[1] = 16'h0000; r5[1] = 16'h0000;
        wait_frames(6);
        check(full_duplex[1] == 1'b1, "R7 duplex unaffected", int'(full_duplex[1]), 1);

        // port 0 negotiates
        r1[0] = 16'h0024;
        wait_frames(6);

        // R10: enable low
        an_enable = 1'b0;
        repeat (300) @(posedge clk);
        begin
            int fs;
            fs = frames_started;
            repeat (600) @(posedge clk);
            #1;
            check(frames_started == fs, "R10 no frame while disabled", frames_started, fs);
            check(mdc == 0 && mdio_oe == 0, "R10 bus idle while disabled", int'({mdc, mdio_oe}), 0);
        end
        an_enable = 1'b1;
        wait_frames(4);

        // constrained random
        repeat (200) begin
            wait_frames(1);
            if ($urandom_range(2) == 0) begin
                int p;
                p = $urandom_range(1);
                r1[p][5] = ~r1[p][5];
                r1[p][2] = 1'($urandom_range(1));
                r4[p] = 16'($urandom) & 16'h03E0;
                r5[p] = 16'($urandom) & 16'h03E0;
            end
        end
        wait_frames(2);
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", frames_done, 0);
        finish_run();
    end
endmodule